// File: doc/BRIEF.md
# Indirect MMD Register Access Sequencer

This block turns one request for an extended (MMD) PHY register into the fixed series of four Clause 22 management frames needed to reach that register through two Clause 22 registers. The request carries a 5-bit PHY address, a 5-bit device address, a 16-bit register address within that device, a read/write flag and 16-bit write data. The block passes each frame to a downstream MDIO frame engine over a start/done handshake, and returns the 16-bit read data together with a one-cycle done pulse.

The first frame writes the access-control register (Clause 22 address 0x0d) with the command field set to address mode and the device address filled in. The second frame writes the target register address into the address/data register (Clause 22 address 0x0e). The third frame writes the access-control register again, this time with the command field set to data mode. The fourth frame reads or writes 0x0e. Bit-level serialisation belongs to the frame engine.

The controller is one state machine with ten states: `S_IDLE`, one start/wait pair per frame (`S_F0_GO`/`S_F0_WT`, `S_F1_GO`/`S_F1_WT`, `S_F2_GO`/`S_F2_WT`, `S_F3_GO`/`S_F3_WT`), and `S_DONE`. Its transitions are:
- `S_IDLE` to `S_F0_GO` when a request is accepted.
- Each `GO` state moves to its `WT` state unconditionally.
- Each `WT` state moves on when `frm_done` is high: `S_F0_WT` to `S_F1_GO`, `S_F1_WT` to `S_F2_GO`, `S_F2_WT` to `S_F3_GO`, and `S_F3_WT` to `S_DONE`.
- `S_DONE` returns to `S_IDLE` unconditionally.

Top module: `mmd_indirect_seq`

## Requirements
- R1: After reset, `busy`, `done`, `frm_start`, `frm_write`, `frm_phy`, `frm_regad`, `frm_wdata` and `rdata` are all zero.
- R2: A request (`req_valid` high while `busy` is low) is accepted at that clock edge. `busy` is high from the next cycle until the done cycle, inclusive.
- R3: An accepted request produces exactly four frames, in this order:
  - Frame 1 writes register 0x0d.
  - Frame 2 writes register 0x0e with the 16-bit register address as data.
  - Frame 3 writes register 0x0d.
  - Frame 4 targets register 0x0e. It is a write carrying `req_wdata` when `req_write` is 1, and a read with zero write data when `req_write` is 0.
- R4: The control word written to 0x0d carries the command in bits 15:14 (value 0 for address mode on frame 1, value 1 for data mode on frame 3), zeros in bits 13:5, and the device address in bits 4:0.
- R5: Frame handshake and frame outputs:
  - `frm_start` is high for exactly one cycle per frame.
  - `frm_write`, `frm_phy`, `frm_regad` and `frm_wdata` hold their values from that cycle until the cycle in which `frm_done` is high.
  - The next frame's start comes one cycle after that `frm_done` cycle.
  - Outside a frame, these outputs are zero.
- R6: `frm_done` is ignored in every state except the frame-wait states, including the cycle in which `frm_start` is high.
- R7: `req_valid` is ignored while `busy` is high, including the done cycle.
- R8: `done` is high for exactly one cycle, the cycle after `frm_done` ends frame 4. `busy` is still high in that cycle and is low in the next.
- R9: `rdata` changes only when frame 4 of a read ends. It then takes `frm_rdata` from that cycle and holds it. Values returned on frames 1 to 3, or on a write's frame 4, are discarded.
- R10: `frm_phy` carries the request's PHY address on all four frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_phy | input | 5 | PHY address of the request |
| req_devad | input | 5 | MMD device address |
| req_reg | input | 16 | Register address inside the device |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| frm_start | output | 1 | Frame start pulse to frame engine |
| frm_write | output | 1 | Frame is a write |
| frm_phy | output | 5 | Frame PHY address |
| frm_regad | output | 5 | Frame Clause 22 register address |
| frm_wdata | output | 16 | Frame write data |
| frm_done | input | 1 | Frame engine completion |
| frm_rdata | input | 16 | Frame engine read data, valid with frm_done |

## Verification
The coincidence that matters is a new request arriving in the same cycle as the done pulse. It is provoked by raising `req_valid` at the moment `done` becomes visible, and is judged by `busy` falling the next cycle and no further `frm_start` following. A second coincidence is a `frm_done` arriving in the same cycle as a `frm_start`. It is provoked by an extra done pulse injected in that cycle, and is judged by the sequence still waiting for the engine's real completion. Both cases are compared against the bench's cycle-level model on every clock, and the number of frame starts is compared with the number of accepted requests.

// File: rtl/mmd_seq_pkg.sv
package mmd_seq_pkg;
    localparam int PHY_W   = 5;
    localparam int DEV_W   = 5;
    localparam int REGAD_W = 5;
    localparam int DATA_W  = 16;
    localparam int CMD_W   = 2;
    localparam int NFRAMES = 4;
    localparam int FIDX_W  = $clog2(NFRAMES);

    localparam logic [REGAD_W-1:0] CTL_REGAD  = 5'h0d;
    localparam logic [REGAD_W-1:0] ADAT_REGAD = 5'h0e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_F0_GO, S_F0_WT,
        S_F1_GO, S_F1_WT,
        S_F2_GO, S_F2_WT,
        S_F3_GO, S_F3_WT,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/mmd_ctl_word.sv
module mmd_ctl_word #(
    parameter int DATA_W = 16,
    parameter int DEV_W  = 5,
    parameter int CMD_W  = 2
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DEV_W-1:0]  devad,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_W = DATA_W - CMD_W - DEV_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {cmd, {PAD_W{1'b0}}, devad};
        end else begin : g_nopad
            assign word = {cmd, devad};
        end
    endgenerate
endmodule

// File: rtl/mmd_frame_mux.sv
module mmd_frame_mux
    import mmd_seq_pkg::*;
#(
    parameter int PHY_W  = mmd_seq_pkg::PHY_W,
    parameter int DEV_W  = mmd_seq_pkg::DEV_W,
    parameter int DATA_W = mmd_seq_pkg::DATA_W,
    parameter int CMD_W  = mmd_seq_pkg::CMD_W
) (
    input  logic                active,
    input  logic [FIDX_W-1:0]   frame_idx,
    input  logic [PHY_W-1:0]    phy,
    input  logic [DEV_W-1:0]    devad,
    input  logic [DATA_W-1:0]   regaddr,
    input  logic                is_write,
    input  logic [DATA_W-1:0]   wdata,
    output logic                frm_write,
    output logic [PHY_W-1:0]    frm_phy,
    output logic [REGAD_W-1:0]  frm_regad,
    output logic [DATA_W-1:0]   frm_wdata
);
    logic [DATA_W-1:0] ctl_w [2];

    // index 0 = address-mode command, index 1 = data-mode command
    for (genvar ci = 0; ci < 2; ci++) begin : g_ctl
        mmd_ctl_word #(
            .DATA_W (DATA_W),
            .DEV_W  (DEV_W),
            .CMD_W  (CMD_W)
        ) u_ctl (
            .cmd   (CMD_W'(ci)),
            .devad (devad),
            .word  (ctl_w[ci])
        );
    end

    always_comb begin
        frm_write = 1'b0;
        frm_phy   = '0;
        frm_regad = '0;
        frm_wdata = '0;
        if (active) begin
            frm_phy = phy;
            unique case (frame_idx)
                2'd0: begin
                    frm_write = 1'b1;
                    frm_regad = CTL_REGAD;
                    frm_wdata = ctl_w[0];
                end
                2'd1: begin
                    frm_write = 1'b1;
                    frm_regad = ADAT_REGAD;
                    frm_wdata = regaddr;
                end
                2'd2: begin
                    frm_write = 1'b1;
                    frm_regad = CTL_REGAD;
                    frm_wdata = ctl_w[1];
                end
                default: begin
                    frm_write = is_write;
                    frm_regad = ADAT_REGAD;
                    frm_wdata = is_write ? wdata : '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mmd_seq_fsm.sv
module mmd_seq_fsm
    import mmd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              is_write,
    input  logic              frm_done,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              active,
    output logic              frm_start,
    output logic [FIDX_W-1:0] frame_idx,
    output logic              cap_en
);
    seq_state_e state, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_n = S_F0_GO;
            S_F0_GO: state_n = S_F0_WT;
            S_F0_WT: if (frm_done) state_n = S_F1_GO;
            S_F1_GO: state_n = S_F1_WT;
            S_F1_WT: if (frm_done) state_n = S_F2_GO;
            S_F2_GO: state_n = S_F2_WT;
            S_F2_WT: if (frm_done) state_n = S_F3_GO;
            S_F3_GO: state_n = S_F3_WT;
            S_F3_WT: if (frm_done) state_n = S_DONE;
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        active    = 1'b1;
        frm_start = 1'b0;
        frame_idx = '0;
        unique case (state)
            S_IDLE:  begin busy = 1'b0; active = 1'b0; end
            S_F0_GO: begin frm_start = 1'b1; frame_idx = 2'd0; end
            S_F0_WT: frame_idx = 2'd0;
            S_F1_GO: begin frm_start = 1'b1; frame_idx = 2'd1; end
            S_F1_WT: frame_idx = 2'd1;
            S_F2_GO: begin frm_start = 1'b1; frame_idx = 2'd2; end
            S_F2_WT: frame_idx = 2'd2;
            S_F3_GO: begin frm_start = 1'b1; frame_idx = 2'd3; end
            S_F3_WT: frame_idx = 2'd3;
            S_DONE:  begin done = 1'b1; active = 1'b0; end
            default: begin busy = 1'b0; active = 1'b0; end
        endcase
    end

    assign accept = (state == S_IDLE) && req_valid;
    assign cap_en = (state == S_F3_WT) && frm_done && !is_write;

    // R5: one start per frame
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !frm_start);
    // R2: an accepted request starts frame 1 next cycle
    p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (frm_start && busy));
    // R8: done is single and releases busy
    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R7: busy is held until the done cycle
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R6: a done during a start cycle does not launch another start
    p_done_in_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && frm_done) |=> (!frm_start && busy && !done));
endmodule

// File: rtl/mmd_rdata_cap.sv
module mmd_rdata_cap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (cap_en) dout <= din;
    end
endmodule

// File: rtl/mmd_indirect_seq.sv
module mmd_indirect_seq
    import mmd_seq_pkg::*;
#(
    parameter int PHY_W  = mmd_seq_pkg::PHY_W,
    parameter int DEV_W  = mmd_seq_pkg::DEV_W,
    parameter int DATA_W = mmd_seq_pkg::DATA_W,
    parameter int CMD_W  = mmd_seq_pkg::CMD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PHY_W-1:0]   req_phy,
    input  logic [DEV_W-1:0]   req_devad,
    input  logic [DATA_W-1:0]  req_reg,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic               frm_start,
    output logic               frm_write,
    output logic [PHY_W-1:0]   frm_phy,
    output logic [REGAD_W-1:0] frm_regad,
    output logic [DATA_W-1:0]  frm_wdata,
    input  logic               frm_done,
    input  logic [DATA_W-1:0]  frm_rdata
);
    localparam int ZHI = DATA_W - CMD_W - 1;

    logic              accept, active, cap_en;
    logic [FIDX_W-1:0] frame_idx;
    logic [PHY_W-1:0]  phy_q;
    logic [DEV_W-1:0]  dev_q;
    logic [DATA_W-1:0] reg_q, wd_q;
    logic              wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
            dev_q <= '0;
            reg_q <= '0;
            wd_q  <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            phy_q <= req_phy;
            dev_q <= req_devad;
            reg_q <= req_reg;
            wd_q  <= req_wdata;
            wr_q  <= req_write;
        end
    end

    mmd_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .is_write  (wr_q),
        .frm_done  (frm_done),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .active    (active),
        .frm_start (frm_start),
        .frame_idx (frame_idx),
        .cap_en    (cap_en)
    );

    mmd_frame_mux #(
        .PHY_W  (PHY_W),
        .DEV_W  (DEV_W),
        .DATA_W (DATA_W),
        .CMD_W  (CMD_W)
    ) u_mux (
        .active    (active),
        .frame_idx (frame_idx),
        .phy       (phy_q),
        .devad     (dev_q),
        .regaddr   (reg_q),
        .is_write  (wr_q),
        .wdata     (wd_q),
        .frm_write (frm_write),
        .frm_phy   (frm_phy),
        .frm_regad (frm_regad),
        .frm_wdata (frm_wdata)
    );

    mmd_rdata_cap #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (frm_rdata),
        .dout   (rdata)
    );

    // R4: padding bits of a control frame stay zero
    p_ctl_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && frm_regad == CTL_REGAD) |-> (frm_wdata[ZHI:DEV_W] == '0));
    // R9: read data only moves as the done cycle begins
    p_rdata_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);
    // R5: frame fields hold while waiting for the engine
    p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !frm_start) |-> ($stable(frm_regad) && $stable(frm_wdata) && $stable(frm_phy)));
    // R1: nothing is driven to the engine while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!frm_start && !frm_write && frm_regad == '0));
endmodule

// File: tb/mmd_indirect_seq_tb.sv
module mmd_indirect_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_devad = '0;
    logic [15:0] req_reg = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, frm_start, frm_write;
    logic [15:0] rdata, frm_wdata;
    logic [4:0]  frm_phy, frm_regad;
    logic        eng_done = 1'b0;
    logic        spur_done = 1'b0;
    logic        frm_done;
    logic [15:0] frm_rdata = '0;

    assign frm_done = eng_done | spur_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmd_indirect_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phy(req_phy),
        .req_devad(req_devad), .req_reg(req_reg), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .frm_start(frm_start), .frm_write(frm_write), .frm_phy(frm_phy),
        .frm_regad(frm_regad), .frm_wdata(frm_wdata), .frm_done(frm_done),
        .frm_rdata(frm_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // frame engine model
    int          eng_lat = 1;
    logic [15:0] eng_rd = 16'h0000;
    int          eng_cnt = 0;
    bit          eng_pend = 0;
    int          n_starts = 0;
    int          n_dones = 0;

    always @(negedge clk) begin
        eng_done = 1'b0;
        if (!rst_n) begin
            eng_pend = 0;
        end else begin
            if (eng_pend) begin
                eng_cnt--;
                if (eng_cnt <= 0) begin
                    eng_done  = 1'b1;
                    eng_pend  = 0;
                    frm_rdata = frm_write ? 16'hBAD1 : eng_rd;
                end
            end
            if (frm_start) begin
                eng_pend = 1;
                eng_cnt  = eng_lat;
                n_starts++;
            end
            if (done) n_dones++;
        end
    end

    // cycle-level reference model: phase 0 idle, 1 start, 2 wait, 3 done
    int          m_ph = 0;
    int          m_fr = 0;
    int          m_acc = 0;
    logic [4:0]  m_phy, m_dev;
    logic [15:0] m_reg, m_wd;
    logic [15:0] m_rd = '0;
    logic        m_wr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_fr = 0; m_rd = '0; m_acc = 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_phy = req_phy; m_dev = req_devad; m_reg = req_reg;
                    m_wd = req_wdata; m_wr = req_write;
                    m_ph = 1; m_fr = 0; m_acc++;
                end
                1: m_ph = 2;
                2: if (frm_done) begin
                    if (m_fr == 3) begin
                        if (!m_wr) m_rd = frm_rdata;
                        m_ph = 3;
                    end else begin
                        m_fr++;
                        m_ph = 1;
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic        ew;
            logic [4:0]  ea;
            logic [15:0] ed;
            logic [4:0]  ep;
            ew = 0; ea = 0; ed = 0; ep = 0;
            if (m_ph == 1 || m_ph == 2) begin
                ep = m_phy;
                case (m_fr)
                    0: begin ew = 1; ea = 5'h0d; ed = {2'b00, 9'b0, m_dev}; end
                    1: begin ew = 1; ea = 5'h0e; ed = m_reg; end
                    2: begin ew = 1; ea = 5'h0d; ed = {2'b01, 9'b0, m_dev}; end
                    default: begin ew = m_wr; ea = 5'h0e; ed = m_wr ? m_wd : 16'h0; end
                endcase
            end
            chk(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
            chk(done == (m_ph == 3), "R8 done", done, m_ph == 3);
            chk(frm_start == (m_ph == 1), "R5 frm_start", frm_start, m_ph == 1);
            chk(frm_write == ew, "R3 frm_write", frm_write, ew);
            chk(frm_regad == ea, "R3 frm_regad", frm_regad, ea);
            chk(frm_wdata == ed, (ea == 5'h0d) ? "R4 control word" : "R3 frm_wdata", frm_wdata, ed);
            chk(frm_phy == ep, "R10 frm_phy", frm_phy, ep);
            chk(rdata == m_rd, "R9 rdata", rdata, m_rd);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic set_req(input logic [4:0] p, input logic [4:0] d, input logic [15:0] r,
                           input logic w, input logic [15:0] wd);
        req_phy = p; req_devad = d; req_reg = r; req_write = w; req_wdata = wd;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic do_req(input logic [4:0] p, input logic [4:0] d, input logic [15:0] r,
                          input logic w, input logic [15:0] wd);
        @(negedge clk);
        set_req(p, d, r, w, wd);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !frm_start, "R1 reset control", {busy, done, frm_start}, 0);
        chk(rdata == 0 && frm_wdata == 0 && frm_regad == 0 && frm_phy == 0 && !frm_write,
            "R1 reset data", rdata, 0);

        // R3 R4 write, short latency
        eng_lat = 1;
        s0 = n_starts;
        do_req(5'h03, 5'h01, 16'h1234, 1'b1, 16'hABCD);
        chk(n_starts - s0 == 4, "R3 frame count write", n_starts - s0, 4);

        // R9 read with longer latency, all-ones fields
        eng_lat = 3; eng_rd = 16'h5A5A;
        do_req(5'h1f, 5'h1f, 16'hFFFF, 1'b0, 16'h7777);
        chk(rdata == 16'h5A5A, "R9 read data", rdata, 16'h5A5A);

        // R9 write leaves rdata alone
        eng_lat = 2; eng_rd = 16'h0F0F;
        do_req(5'h00, 5'h00, 16'h0000, 1'b1, 16'hFFFF);
        chk(rdata == 16'h5A5A, "R9 rdata held after write", rdata, 16'h5A5A);

        // R7 requests while busy and in the done cycle
        eng_lat = 2; eng_rd = 16'hC3C3;
        s0 = n_starts;
        @(negedge clk);
        set_req(5'h05, 5'h07, 16'h0042, 1'b0, 16'h0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        set_req(5'h11, 5'h02, 16'h9999, 1'b1, 16'h1111);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        set_req(5'h12, 5'h03, 16'h8888, 1'b1, 16'h2222);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy, "R7 request in done cycle ignored", busy, 0);
        repeat (4) @(negedge clk);
        chk(n_starts - s0 == 4, "R7 frame count", n_starts - s0, 4);
        chk(rdata == 16'hC3C3, "R9 read data second", rdata, 16'hC3C3);

        // R6 spurious engine done while idle
        spur_done = 1'b1;
        @(negedge clk);
        spur_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && n_starts - s0 == 4, "R6 idle done ignored", busy, 0);

        // R6 done in a start cycle
        eng_lat = 3;
        s0 = n_starts;
        @(negedge clk);
        set_req(5'h0a, 5'h15, 16'hA5A5, 1'b1, 16'h3C3C);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        spur_done = frm_start;
        @(negedge clk);
        spur_done = 1'b0;
        chk(busy && !frm_start, "R6 done in start cycle ignored", {busy, frm_start}, 2'b10);
        wait_done();
        @(negedge clk);
        chk(n_starts - s0 == 4, "R6 frame count", n_starts - s0, 4);

        // R2 R8 back-to-back reads with req_valid held
        eng_lat = 1; eng_rd = 16'h0E0E;
        s0 = n_dones;
        @(negedge clk);
        set_req(5'h01, 5'h1e, 16'h0001, 1'b0, 16'h0);
        req_valid = 1'b1;
        wait_done();
        @(negedge clk);
        eng_rd = 16'hE0E0;
        wait_done();
        req_valid = 1'b0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk(n_dones - s0 == 2, "R8 two done pulses", n_dones - s0, 2);
        chk(rdata == 16'hE0E0, "R9 back-to-back read", rdata, 16'hE0E0);
        chk(n_starts == 4 * m_acc, "R3 starts per request", n_starts, 4 * m_acc);

        finish_run();
    end
endmodule